// File: doc/BRIEF.md
# Half-Rate XOR Phase-Frequency Detector

This block compares a reference clock against a divided feedback clock and produces a single drive signal for a charge pump. It halves each input with its own toggle flop and XORs the two halves. The usable phase-detection range is therefore a full 360 degrees, and when the loop is locked the output runs at the reference rate with a duty cycle near one half.

A three-state frequency detector samples the XOR result at every rising edge of either input. This tells it whether the comparison sits on the stable or the unstable slope. On the stable slope the XOR passes straight through. On the unstable slope the output is pinned high or low, depending on which input showed the unstable condition first, and it stays pinned until an edge shows the stable slope again. The result is an output whose average value steers the oscillator toward the reference frequency.

Both inputs are asynchronous to the system clock. Each one is synchronized, and its rising edges are turned into one-cycle pulses. The system clock must run at least four times faster than either input. A polarity bit can invert the final output to flip the sign of the loop gain.

Top module: `halfrate_xor_pfd`

## Requirements
- R1: An input rising edge is seen as exactly one single-cycle pulse. With the default two synchronizer stages, its effect first appears on `pfd_out` after the third rising `clk` edge that follows the input change.
- R2: Each input rising edge toggles that input's half-rate flop. In pass-through, `pfd_out` equals the XOR of the two half-rate flops (C), XORed with `invert`.
- R3: From pass-through, a reference edge that finds C=1 enters forced-high. A feedback edge that finds C=0 enters forced-low.
- R4: Forced-high returns to pass-through only on a reference edge that finds C=0. Forced-low returns only on a feedback edge that finds C=1. All other edges leave a forced state unchanged, and `pfd_out` stays constant while forced.
- R5: The C used for the decision at an edge is the value from before that edge toggles its own half-rate flop.
- R6: When reference and feedback pulses fall in the same cycle, the reference edge is evaluated first. The feedback edge is then evaluated with C as it stands after the reference half-rate flop has toggled.
- R7: When `invert`=1, `pfd_out` is the complement of the value it would have with `invert`=0.
- R8: With `invert`=0, a feedback clock at least 1.5 times faster than the reference keeps `pfd_out` high less than half the time. A feedback clock at least 1.5 times slower keeps it high more than half the time.
- R9: A synchronous active-high `rst` clears both half-rate flops and the synchronizers, selects pass-through, and holds `pfd_out` at 0.
- R10: The detector state is two flags: 11 means pass-through, 10 means forced-high, 01 means forced-low. The value 00 never occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x either input rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| invert | input | 1 | 1 inverts the output polarity |
| pfd_out | output | 1 | Registered detector output |

## Verification
The two functions that can land in the same cycle are the reference-edge decision and the feedback-edge decision. This happens whenever both input edges cross the synchronizers together. The sweep provokes it by running both inputs at equal periods and zero phase offset, which makes every rising edge coincide. Other period pairs bring the edges into coincidence only now and then. In every cycle the bench model resolves such a cycle with the reference decision first and the feedback decision second, using the C left by the reference toggle, and it compares the resulting output bit against `pfd_out`.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Two flags {keep_high, keep_low}: both set means pass-through.
  typedef enum logic [1:0] {
    FD_PASS = 2'b11,
    FD_HIGH = 2'b10,
    FD_LOW  = 2'b01
  } fd_state_t;

  // Decision taken at a reference rising edge, given C before the toggle.
  function automatic fd_state_t fd_on_ref(input fd_state_t s, input logic c);
    fd_state_t n;
    n = s;
    case (s)
      FD_PASS: if (c)  n = FD_HIGH;
      FD_HIGH: if (!c) n = FD_PASS;
      default: n = s;
    endcase
    return n;
  endfunction

  // Decision taken at a feedback rising edge, given C before the toggle.
  function automatic fd_state_t fd_on_fb(input fd_state_t s, input logic c);
    fd_state_t n;
    n = s;
    case (s)
      FD_PASS: if (!c) n = FD_LOW;
      FD_LOW:  if (c)  n = FD_PASS;
      default: n = s;
    endcase
    return n;
  endfunction

  // Output selection: forced states override the XOR value.
  function automatic logic fd_drive(input fd_state_t s, input logic c);
    logic [1:0] f;
    f = s;
    return f[1] & (c | ~f[0]);
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_p
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], async_in};
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise_p = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/pfd_fd_fsm.sv
module pfd_fd_fsm
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ref_p,
  input  logic      fb_p,
  input  logic      c_pre,
  output fd_state_t state_q,
  output fd_state_t state_d
);
  fd_state_t after_ref;
  logic      c_mid;

  always_comb begin
    after_ref = ref_p ? fd_on_ref(state_q, c_pre) : state_q;
    // The reference toggle lands before the feedback edge is judged.
    c_mid     = c_pre ^ ref_p;
    state_d   = fb_p ? fd_on_fb(after_ref, c_mid) : after_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= FD_PASS;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/halfrate_xor_pfd.sv
module halfrate_xor_pfd
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic invert,
  output logic pfd_out
);
  localparam int NCH = 2;
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] pulse;
  logic [NCH-1:0] half_q;
  logic [NCH-1:0] half_d;
  logic           ref_p;
  logic           fb_p;
  logic           ref_half_q;
  logic           fb_half_q;
  logic           c_now;
  logic           c_next;
  fd_state_t      fd_q;
  fd_state_t      fd_d;
  logic           out_q;

  assign raw_in = {fb_in, ref_in};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(raw_in[g]), .rise_p(pulse[g])
    );
    assign half_d[g] = half_q[g] ^ pulse[g];
    always_ff @(posedge clk) begin
      if (rst) half_q[g] <= 1'b0;
      else     half_q[g] <= half_d[g];
    end
  end

  assign ref_p      = pulse[CH_REF];
  assign fb_p       = pulse[CH_FB];
  assign ref_half_q = half_q[CH_REF];
  assign fb_half_q  = half_q[CH_FB];
  assign c_now      = ref_half_q ^ fb_half_q;
  assign c_next     = half_d[CH_REF] ^ half_d[CH_FB];

  pfd_fd_fsm u_fd (
    .clk(clk), .rst(rst), .ref_p(ref_p), .fb_p(fb_p),
    .c_pre(c_now), .state_q(fd_q), .state_d(fd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= fd_drive(fd_d, c_next) ^ invert;
  end

  assign pfd_out = out_q;
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_p,
  input logic       fb_p,
  input logic       ref_half,
  input logic       fb_half,
  input logic [1:0] state_q,
  input logic       invert,
  input logic       pfd_out
);
  assert_ref_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
    ref_p |=> !ref_p);
  assert_fb_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
    fb_p |=> !fb_p);
  assert_ref_half_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_half) |-> $past(ref_p));
  assert_fb_half_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(fb_half) |-> $past(fb_p));
  assert_state_legal_R10: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'b00);
  assert_high_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b11 && $past(state_q) == 2'b10) |-> $past(ref_p));
  assert_low_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b11 && $past(state_q) == 2'b01) |-> $past(fb_p));
  assert_forced_high_out_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b10 && $stable(invert)) |-> (pfd_out == !invert));
  assert_forced_low_out_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b01 && $stable(invert)) |-> (pfd_out == invert));
endmodule

bind halfrate_xor_pfd pfd_chk u_chk (
  .clk(clk), .rst(rst), .ref_p(ref_p), .fb_p(fb_p),
  .ref_half(ref_half_q), .fb_half(fb_half_q), .state_q(fd_q),
  .invert(invert), .pfd_out(pfd_out)
);

// File: tb/sim_halfrate_xor_pfd.sv
module sim_halfrate_xor_pfd;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic invert = 1'b0;
  logic pfd_out;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // Bench model (from R1..R10): input history, half flops, two flags.
  logic [3:0] hr, hf;
  logic       m_rh, m_fh;
  logic [1:0] m_st;
  logic       exp_out;
  int         high_cnt;

  halfrate_xor_pfd #(.SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .invert(invert), .pfd_out(pfd_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic expv, input string req);
    n_vec = n_vec + 1;
    if (act !== expv) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0b expected %0b", req, act, expv);
    end
  endtask

  function automatic logic model_out();
    // R10 encoding: 11 pass, 10 high, 01 low; R7 polarity.
    logic c;
    c = m_rh ^ m_fh;
    if (m_st == 2'b10)      return 1'b1 ^ invert;
    else if (m_st == 2'b01) return 1'b0 ^ invert;
    else                    return c ^ invert;
  endfunction

  task automatic model_update(input logic r, input logic f);
    logic pr, pf, c;
    hr = {hr[2:0], r};
    hf = {hf[2:0], f};
    // R1: an input rise from two steps ago is acted on now.
    pr = hr[2] & ~hr[3];
    pf = hf[2] & ~hf[3];
    // R5/R6: reference first with pre-toggle C, feedback after it.
    if (pr) begin
      c = m_rh ^ m_fh;
      if (m_st == 2'b11 && c)       m_st = 2'b10;   // R3
      else if (m_st == 2'b10 && !c) m_st = 2'b11;   // R4
      m_rh = ~m_rh;
    end
    if (pf) begin
      c = m_rh ^ m_fh;
      if (m_st == 2'b11 && !c)      m_st = 2'b01;   // R3
      else if (m_st == 2'b01 && c)  m_st = 2'b11;   // R4
      m_fh = ~m_fh;
    end
    exp_out = model_out();
  endtask

  task automatic step(input logic r, input logic f, input string req);
    @(negedge clk);
    chk(pfd_out, exp_out, req);
    ref_in = r;
    fb_in  = f;
    @(posedge clk);
    #1;
    model_update(r, f);
  endtask

  task automatic do_reset(input logic inv);
    @(negedge clk);
    rst = 1'b1;
    ref_in = 1'b0;
    fb_in = 1'b0;
    invert = inv;
    repeat (4) @(negedge clk);
    chk(pfd_out, 1'b0, "R9");
    rst = 1'b0;
    hr = '0; hf = '0; m_rh = 1'b0; m_fh = 1'b0; m_st = 2'b11;
    exp_out = model_out();
  endtask

  // One sweep point: periods in clk cycles, phase offsets.
  task automatic run(input logic inv, input int pr, input int pf, input int ph);
    int nsteps;
    nsteps = 1200;
    do_reset(inv);
    high_cnt = 0;
    for (int n = 0; n < nsteps; n++) begin
      logic r, f;
      r = ((n % pr) < pr / 2);
      f = (((n + ph) % pf) < pf / 2);
      step(r, f, (m_st == 2'b11) ? "R2" : "R4");
      if (n >= 400 && (pfd_out ^ inv)) high_cnt = high_cnt + 1;
    end
    // R8: average value steers toward the reference frequency.
    if (pr * 2 >= pf * 3) begin
      n_vec = n_vec + 1;
      if (high_cnt * 2 >= 800) begin
        n_bad = n_bad + 1;
        $display("FAIL R8: actual high %0d/800 expected < 400 (pr=%0d pf=%0d)",
                 high_cnt, pr, pf);
      end
    end else if (pf * 2 >= pr * 3) begin
      n_vec = n_vec + 1;
      if (high_cnt * 2 <= 800) begin
        n_bad = n_bad + 1;
        $display("FAIL R8: actual high %0d/800 expected > 400 (pr=%0d pf=%0d)",
                 high_cnt, pr, pf);
      end
    end
  endtask

  initial begin
    int plist [3];
    plist = '{8, 12, 20};
    hr = '0; hf = '0; m_rh = 1'b0; m_fh = 1'b0; m_st = 2'b11;
    exp_out = 1'b0;

    // R1 latency and R9 reset: directed single reference rise.
    do_reset(1'b0);
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    @(negedge clk);
    chk(pfd_out, 1'b1, "R1");

    // R6: equal periods, zero offset gives coincident edges each period.
    run(1'b0, 8, 8, 0);
    run(1'b1, 8, 8, 0);

    // Sweep: both polarities (R7), period pairs, two phase offsets.
    for (int iv = 0; iv < 2; iv++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int ph = 0; ph < 2; ph++)
            run(iv[0], plist[a], plist[b], ph * 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule